// File: doc/BRIEF.md
# Supply Loss Deselect and Backup Switchover Supervisor

This block sits between a host bus and a battery-backed byte-wide memory. It watches three digital comparator flags. One says the supply is above the upper deselect threshold. One says it is above the lower deselect threshold. One says it is above the backup switchover threshold. From these flags it decides when the memory may be accessed. While the supply is not healthy, the block blocks the chip-enable and write-enable strobes, holds the data outputs in high impedance and reports that it is protecting the memory. It also selects the backup cell whenever the supply is below the switchover level.

Protection on the way up is sticky. After the supply climbs back above the upper threshold, a clock-cycle recovery counter must run out without interruption before access is allowed again. Access then resumes only once the host has released chip-enable, so a bus cycle that was already low while the supply rose is never acted on. On the way down, protection asserts in the same cycle the synchronized flag falls, so a write in flight ends at once and only the addressed location is at risk.

Top module: `pfd_supervisor`

## Requirements
- R1: Each comparator flag passes through two clock stages. A change on a flag input is visible on `protect`, `ready` or `bat_sel` after the second rising clock edge following the change, and not after the first.
- R2: `bat_sel` is 1 exactly when the synchronized switchover flag is 0. It does not depend on the two deselect flags.
- R3: The upper flag counts only when the lower flag and the switchover flag are also set. With `sup_above_hi`=1 and either of the others at 0, the block stays protected indefinitely.
- R4: After the qualified upper flag rises and stays set, with `ce_n_in` high, `ready` rises exactly REC_CYCLES+2 rising edges after the input change, and not one edge earlier.
- R5: If the qualified upper flag drops, even for one cycle, before the recovery count is complete, the count starts over from zero when the flag returns.
- R6: If the recovery count is complete while `ce_n_in` is 0, protection holds until `ce_n_in` is seen at 1. `ready` rises on the first rising edge at which `ce_n_in` is 1.
- R7: While `protect`=1, `mem_ce_n`=1 and `mem_we_n`=1 whatever the host strobes are. A write in progress is cut off in the same cycle that protection asserts.
- R8: While `protect`=1, `out_hiz`=1 whatever `oe_n_in` is.
- R9: While `ready`=1, `mem_ce_n` equals `ce_n_in` and `mem_we_n` equals `we_n_in`. `out_hiz` is 0 only when `ce_n_in`=0, `oe_n_in`=0 and `we_n_in`=1.
- R10: During and right after reset, `protect`=1, `ready`=0, `bat_sel`=1 and `out_hiz`=1. `ready` is always the inverse of `protect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_hi | input | 1 | Supply above upper deselect threshold (asynchronous) |
| sup_above_lo | input | 1 | Supply above lower deselect threshold (asynchronous) |
| sup_above_bat | input | 1 | Supply above backup switchover threshold (asynchronous) |
| ce_n_in | input | 1 | Host chip enable, active low |
| we_n_in | input | 1 | Host write enable, active low |
| oe_n_in | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the memory |
| mem_we_n | output | 1 | Gated write strobe to the memory |
| out_hiz | output | 1 | 1 = data outputs high impedance |
| bat_sel | output | 1 | 1 = memory powered from backup cell |
| protect | output | 1 | Memory deselected and write-protected |
| ready | output | 1 | Normal access permitted |

## Verification
The strobe gating is exercised with all eight combinations of chip, write and output enable while the block is ready. This separates read drive, write and idle behaviour. The same strobes are then applied while the block is protected, to show that none of them reaches the memory. The supply flags are driven in separate patterns: a clean power-up, a one-cycle dip during recovery, the upper flag set alone, the switchover flag set alone, and a collapse during an active write. These patterns tell apart the latency of the synchronizer, the qualification of the thresholds, the restart of the counter and the immediate cut-off. A power-up with chip enable held low shows whether the block waits for the host to release the bus.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic hi;
        logic lo;
        logic bat;
    } sup_flags_t;

    localparam int unsigned FLAG_W = $bits(sup_flags_t);

endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pfd_rec_timer.sv
module pfd_rec_timer #(
    parameter int unsigned REC_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW   = $clog2(REC_CYCLES + 1);
    localparam int unsigned LAST = REC_CYCLES - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run)                          tmr_d.cnt = '0;
        else if (tmr_q.cnt != CW'(LAST))   tmr_d.cnt = tmr_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = run && (tmr_q.cnt == CW'(LAST));
endmodule

// File: rtl/pfd_gate.sv
module pfd_gate (
    input  logic protect,
    input  logic ce_n_in,
    input  logic we_n_in,
    input  logic oe_n_in,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic out_hiz
);
    always_comb begin
        mem_ce_n = ce_n_in | protect;
        mem_we_n = we_n_in | protect;
        out_hiz  = protect | ce_n_in | oe_n_in | ~we_n_in;
    end
endmodule

// File: rtl/pfd_supervisor.sv
module pfd_supervisor
    import pfd_pkg::*;
#(
    parameter int unsigned REC_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_hi,
    input  logic sup_above_lo,
    input  logic sup_above_bat,
    input  logic ce_n_in,
    input  logic we_n_in,
    input  logic oe_n_in,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic out_hiz,
    output logic bat_sel,
    output logic protect,
    output logic ready
);
    typedef struct packed {
        logic ready;
    } ctl_t;

    sup_flags_t flags_raw, flags_s;
    logic       hi_ok, bat_ok, expired;
    ctl_t       ctl_d, ctl_q;

    assign flags_raw = '{hi: sup_above_hi, lo: sup_above_lo, bat: sup_above_bat};

    pfd_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (flags_raw),
        .dout (flags_s)
    );

    // A higher threshold only counts when every lower one is also met.
    assign bat_ok = flags_s.bat;
    assign hi_ok  = flags_s.hi & flags_s.lo & flags_s.bat;

    pfd_rec_timer #(.REC_CYCLES(REC_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (hi_ok),
        .expired(expired)
    );

    always_comb begin
        ctl_d = ctl_q;
        // Leave protection only once the host bus is idle (chip enable high).
        ctl_d.ready = hi_ok & expired & (ctl_q.ready | ce_n_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ready   = ctl_q.ready & hi_ok;
    assign protect = ~ready;
    assign bat_sel = ~bat_ok;

    pfd_gate u_gate (
        .protect (protect),
        .ce_n_in (ce_n_in),
        .we_n_in (we_n_in),
        .oe_n_in (oe_n_in),
        .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n),
        .out_hiz (out_hiz)
    );
endmodule

// File: rtl/pfd_supervisor_chk.sv
module pfd_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic sup_above_hi,
    input logic sup_above_bat,
    input logic ce_n_in,
    input logic mem_ce_n,
    input logic mem_we_n,
    input logic out_hiz,
    input logic bat_sel,
    input logic protect,
    input logic ready
);
    p_strobes_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        protect |-> (mem_ce_n && mem_we_n));

    p_outputs_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        protect |-> out_hiz);

    p_ready_inverse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready == !protect);

    p_hi_low_protects_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && !$past(sup_above_hi, 2)) |-> protect);

    p_bat_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> (bat_sel == !$past(sup_above_bat, 2)));

    p_ready_needs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(ce_n_in));
endmodule

bind pfd_supervisor pfd_supervisor_chk u_chk (.*);

// File: tb/pfd_supervisor_test.sv
module pfd_supervisor_test;
    localparam int REC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, lo = 1'b0, bat = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic mem_ce_n, mem_we_n, out_hiz, bat_sel, protect, ready;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    pfd_supervisor #(.REC_CYCLES(REC)) uut (
        .clk(clk), .rst_n(rst_n),
        .sup_above_hi(hi), .sup_above_lo(lo), .sup_above_bat(bat),
        .ce_n_in(ce_n), .we_n_in(we_n), .oe_n_in(oe_n),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .out_hiz(out_hiz),
        .bat_sel(bat_sel), .protect(protect), .ready(ready)
    );

    // {ce_n, we_n, oe_n, exp mem_ce_n, exp mem_we_n, exp out_hiz} while ready (R9)
    localparam logic [5:0] VEC [8] = '{
        6'b010_010, 6'b011_011, 6'b000_001, 6'b001_001,
        6'b110_111, 6'b100_101, 6'b101_101, 6'b111_111
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic power_up();
        bat = 1; lo = 1; hi = 1;
        edges(REC + 2);
    endtask

    initial begin
        repeat (400) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        edges(3);
        chk("R10 protect in reset", protect, 1'b1);
        chk("R10 ready in reset", ready, 1'b0);
        chk("R10 bat_sel in reset", bat_sel, 1'b1);
        chk("R10 out_hiz in reset", out_hiz, 1'b1);
        rst_n = 1;
        edges(2);
        chk("R10 protect after reset", protect, 1'b1);

        // R2: switchover flag alone
        bat = 1;
        edges(1);
        chk("R1 bat_sel one edge", bat_sel, 1'b1);
        edges(1);
        chk("R2 bat_sel two edges", bat_sel, 1'b0);
        chk("R2 still protected", protect, 1'b1);

        // R3: upper flag without lower flag
        hi = 1;
        edges(REC + 8);
        chk("R3 hi without lo", protect, 1'b1);
        chk("R2 bat_sel ignores deselect flags", bat_sel, 1'b0);

        // R4: clean power-up timing
        hi = 0; edges(3);
        hi = 1; lo = 1;
        edges(REC + 1);
        chk("R4 not ready one edge early", ready, 1'b0);
        edges(1);
        chk("R4 ready on time", ready, 1'b1);
        chk("R10 protect inverse", protect, 1'b0);

        // R9: strobe table while ready
        foreach (VEC[i]) begin
            {ce_n, we_n, oe_n} = VEC[i][5:3];
            #1;
            chk($sformatf("R9 vec%0d mem_ce_n", i), mem_ce_n, VEC[i][2]);
            chk($sformatf("R9 vec%0d mem_we_n", i), mem_we_n, VEC[i][1]);
            chk($sformatf("R9 vec%0d out_hiz", i), out_hiz, VEC[i][0]);
        end

        // R7/R8: collapse during a write
        ce_n = 0; we_n = 0; oe_n = 1;
        edges(1);
        hi = 0;
        edges(1);
        chk("R1 write survives one edge", mem_we_n, 1'b0);
        edges(1);
        chk("R7 write cut off", mem_we_n, 1'b1);
        chk("R7 ce blocked", mem_ce_n, 1'b1);
        we_n = 1; oe_n = 0;
        #1;
        chk("R8 hiz while protected", out_hiz, 1'b1);
        chk("R7 ce still blocked", mem_ce_n, 1'b1);

        // R5: dip during recovery restarts count
        ce_n = 1; oe_n = 1; we_n = 1;
        hi = 1;
        edges(10);
        hi = 0; edges(1);
        hi = 1;
        edges(REC + 1);
        chk("R5 restart not early", ready, 1'b0);
        edges(1);
        chk("R5 ready after full count", ready, 1'b1);

        // R6: power-up with chip enable held low
        hi = 0; edges(4);
        ce_n = 0;
        hi = 1;
        edges(REC + 6);
        chk("R6 held while ce low", protect, 1'b1);
        chk("R6 ce blocked", mem_ce_n, 1'b1);
        ce_n = 1;
        #1;
        chk("R6 not before edge", ready, 1'b0);
        edges(1);
        chk("R6 ready after ce release", ready, 1'b1);

        // R2/R3: switchover flag loss forces backup and protection
        bat = 0;
        edges(2);
        chk("R2 backup selected", bat_sel, 1'b1);
        chk("R3 bat loss protects", protect, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule